// File: doc/BRIEF.md
# Alarm Countdown Timer

This block counts down a relative alarm for the clock core. Software never gives it an absolute alarm time. It loads the time left until the alarm, split into days, hours, minutes and seconds. While the counter is enabled, each one-second tick takes one second off that value. Seconds, minutes and hours borrow across their boundaries at 60, 60 and 24.

The step that takes the count to zero raises a pending flag, and counting then stops. Counting resumes only when software loads a new value. A separate interrupt-enable bit routes the pending flag onto a level interrupt output. Software clears the flag by writing one to its status bit.

Software reaches the block through a simple register write strobe and a combinational read port. Registers sit at byte offsets 0x0c (count), 0x14 (counter enable), 0x18 (interrupt enable) and 0x1c (status).

Top module: `alarm_countdown`

## Requirements
- R1: After reset, all four registers read zero and `irqOut` is low.
- R2: The count register at 0x0c holds seconds in bits 5:0, minutes in bits 13:8, hours in bits 20:16 and days from bit 21 upward (8 bits by default, up to 255). A write there loads the value exactly and it reads back unchanged.
- R3: While bit 8 of the control register at 0x14 is set, each cycle with `secTick` high lowers a nonzero count by one second. While that bit is clear, ticks leave the count unchanged.
- R4: A seconds field at 0 reloads to 59 and borrows from minutes. Minutes at 0 reload to 59 and borrow from hours. Hours at 0 reload to 23 and borrow one day.
- R5: The tick that takes the count from one second to zero sets the pending bit (bit 0 at 0x1c). Once the count is zero, further ticks neither change it nor raise pending again.
- R6: `irqOut` is high exactly when pending is set and bit 0 of the interrupt-enable register at 0x18 is set.
- R7: Writing 1 to bit 0 at 0x1c clears pending. Writing 0 there leaves pending unchanged.
- R8: When a tick sets pending in the same cycle as a clearing write, pending ends up set.
- R9: A count write in the same cycle as a tick loads the written value and ignores the tick. Writing zero to the count register clears the count and does not raise pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read byte offset |
| rdData | output | 32 | Read data, combinational from `rdAddr` |
| irqOut | output | 1 | Level alarm interrupt |

## Verification
The countdown is tried with loads that stay inside the seconds field, loads that exactly hit a minute, hour or day boundary, and loads at the maximum day count. One tick across a boundary tells whether each reload value (59, 59, 23) and the borrow into the next field are right. Runs that tick past zero separate a correct stop-at-zero from an underflow or a repeated pending event. Directed cases use equal-cycle tick and register writes to tell the priority of a count load over a tick, and of a pending set over a clearing write.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int SEC_W   = 6;
  localparam int MIN_W   = 6;
  localparam int HOUR_W  = 5;
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 8;
  localparam int HOUR_LSB = 16;
  localparam int DAY_LSB  = 21;
  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int RUN_BIT  = 8;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } cntStrobe_t;
endpackage

// File: rtl/alarm_datapath.sv
module alarm_datapath
  import alarm_pkg::*;
#(
  parameter int DAY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobe_t        strb,
  input  logic [31:0]       loadWord,
  output logic [31:0]       countWord,
  output logic              cntZero,
  output logic              lastSec
);
  logic [SEC_W-1:0]  secQ,  secD;
  logic [MIN_W-1:0]  minQ,  minD;
  logic [HOUR_W-1:0] hourQ, hourD;
  logic [DAY_W-1:0]  dayQ,  dayD;

  always_comb begin
    secD  = secQ;
    minD  = minQ;
    hourD = hourQ;
    dayD  = dayQ;
    if (secQ != '0) begin
      secD = secQ - 1'b1;
    end else begin
      secD = SEC_W'(SEC_MAX);
      if (minQ != '0) begin
        minD = minQ - 1'b1;
      end else begin
        minD = MIN_W'(MIN_MAX);
        if (hourQ != '0) begin
          hourD = hourQ - 1'b1;
        end else begin
          hourD = HOUR_W'(HOUR_MAX);
          dayD  = dayQ - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      dayQ  <= '0;
    end else if (strb.loadCnt) begin
      secQ  <= loadWord[SEC_LSB  +: SEC_W];
      minQ  <= loadWord[MIN_LSB  +: MIN_W];
      hourQ <= loadWord[HOUR_LSB +: HOUR_W];
      dayQ  <= loadWord[DAY_LSB  +: DAY_W];
    end else if (strb.decCnt) begin
      secQ  <= secD;
      minQ  <= minD;
      hourQ <= hourD;
      dayQ  <= dayD;
    end
  end

  always_comb begin
    countWord = '0;
    countWord[SEC_LSB  +: SEC_W]  = secQ;
    countWord[MIN_LSB  +: MIN_W]  = minQ;
    countWord[HOUR_LSB +: HOUR_W] = hourQ;
    countWord[DAY_LSB  +: DAY_W]  = dayQ;
  end

  assign cntZero = (secQ == '0) && (minQ == '0) && (hourQ == '0) && (dayQ == '0);
  assign lastSec = (secQ == SEC_W'(1)) && (minQ == '0) && (hourQ == '0) && (dayQ == '0);
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(12),
  parameter logic [ADDR_W-1:0] OFS_RUN   = ADDR_W'(20),
  parameter logic [ADDR_W-1:0] OFS_IRQEN = ADDR_W'(24),
  parameter logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(28)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              cntZero,
  input  logic              lastSec,
  output cntStrobe_t        strb,
  output logic              runEn,
  output logic              irqEnB,
  output logic              pendB
);
  logic wrCount, wrRun, wrIrq, wrStat, setPend, clrPend;

  assign wrCount = wrEn && (wrAddr == OFS_COUNT);
  assign wrRun   = wrEn && (wrAddr == OFS_RUN);
  assign wrIrq   = wrEn && (wrAddr == OFS_IRQEN);
  assign wrStat  = wrEn && (wrAddr == OFS_STAT);

  assign strb.loadCnt = wrCount;
  assign strb.decCnt  = secTick && runEn && !cntZero && !wrCount;
  assign setPend      = strb.decCnt && lastSec;
  assign clrPend      = wrStat && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn  <= 1'b0;
      irqEnB <= 1'b0;
      pendB  <= 1'b0;
    end else begin
      if (wrRun) runEn  <= wrData[RUN_BIT];
      if (wrIrq) irqEnB <= wrData[0];
      if (setPend)      pendB <= 1'b1;
      else if (clrPend) pendB <= 1'b0;
    end
  end
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DAY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] OFS_COUNT = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_RUN   = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] OFS_IRQEN = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(28);

  cntStrobe_t  strb;
  logic [31:0] countWord;
  logic        cntZero, lastSec, runEn, irqEnB, pendB;

  alarm_ctrl #(
    .ADDR_W(ADDR_W), .OFS_COUNT(OFS_COUNT), .OFS_RUN(OFS_RUN),
    .OFS_IRQEN(OFS_IRQEN), .OFS_STAT(OFS_STAT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .cntZero(cntZero), .lastSec(lastSec),
    .strb(strb), .runEn(runEn), .irqEnB(irqEnB), .pendB(pendB)
  );

  alarm_datapath #(.DAY_W(DAY_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadWord(wrData),
    .countWord(countWord), .cntZero(cntZero), .lastSec(lastSec)
  );

  always_comb begin
    rdData = '0;
    case (rdAddr)
      OFS_COUNT: rdData = countWord;
      OFS_RUN:   rdData[RUN_BIT] = runEn;
      OFS_IRQEN: rdData[0] = irqEnB;
      OFS_STAT:  rdData[0] = pendB;
      default:   rdData = '0;
    endcase
  end

  assign irqOut = pendB && irqEnB;
endmodule

// File: rtl/alarm_countdown_chk.sv
module alarm_countdown_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic [31:0]       countWord,
  input logic              runEn,
  input logic              irqEnB,
  input logic              pendB,
  input logic              irqOut
);
  logic wrCnt, wrSt;
  assign wrCnt = wrEn && (wrAddr == ADDR_W'(12));
  assign wrSt  = wrEn && (wrAddr == ADDR_W'(28));

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrCnt) |=> $stable(countWord));
  // R5
  zero_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countWord == 32'd0 && !wrCnt) |=> (countWord == 32'd0));
  // R5
  pend_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendB) |-> $past(secTick && runEn));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> irqEnB);
  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSt && wrData[0] && !secTick) |=> !pendB);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && runEn && countWord == 32'd1 && !wrCnt) |=> pendB);
endmodule

bind alarm_countdown alarm_countdown_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .countWord(countWord), .runEn(runEn), .irqEnB(irqEnB),
  .pendB(pendB), .irqOut(irqOut)
);

// File: tb/tb_alarm_countdown.sv
module tb_alarm_countdown;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_CNT = 5'h0c, A_RUN = 5'h14, A_IRQ = 5'h18, A_ST = 5'h1c;
  // vectors: days, hours, minutes, seconds, ticks
  localparam int NVEC = 8;
  localparam int vecTab [0:NVEC-1][0:4] = '{
    '{0, 0, 0, 5, 3},   '{0, 0, 1, 0, 1},   '{0, 1, 0, 0, 1},
    '{1, 0, 0, 0, 1},   '{0, 0, 0, 2, 2},   '{0, 0, 0, 2, 6},
    '{2, 0, 0, 1, 2},   '{255, 0, 0, 0, 3}
  };

  logic clk = 1'b0, rstN = 1'b0, secTick = 1'b0, wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic irqOut;
  int errors = 0, checks = 0;
  bit finished = 0;

  alarm_countdown dut (.clk(clk), .rstN(rstN), .secTick(secTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqOut(irqOut));

  always #2 clk = ~clk;

  function automatic logic [31:0] packSecs(int t);
    int d, h, m, s;
    d = t / 86400; t = t % 86400;
    h = t / 3600;  t = t % 3600;
    m = t / 60;    s = t % 60;
    return 32'(s) | (32'(m) << 8) | (32'(h) << 16) | (32'(d) << 21);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); secTick = 1;
      @(negedge clk); secTick = 0;
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_CNT, v); check("R1 count", v, 0);
    rd(A_RUN, v); check("R1 run", v, 0);
    rd(A_IRQ, v); check("R1 irqen", v, 0);
    rd(A_ST, v);  check("R1 status", v, 0);
    check("R1 irqOut", {31'd0, irqOut}, 0);

    // R2 layout readback
    wr(A_CNT, 32'h1F17_3B2A & 32'h1FFF_3F3F);
    rd(A_CNT, v); check("R2 readback", v, 32'h1F17_3B2A & 32'h1FFF_3F3F);

    // table walk: R3 R4 R5
    for (int k = 0; k < NVEC; k++) begin
      int tot, left;
      tot = vecTab[k][0]*86400 + vecTab[k][1]*3600 + vecTab[k][2]*60 + vecTab[k][3];
      left = (tot > vecTab[k][4]) ? tot - vecTab[k][4] : 0;
      wr(A_RUN, 0);
      wr(A_ST, 1);
      wr(A_CNT, packSecs(tot));
      wr(A_RUN, 32'h100);
      tick(vecTab[k][4]);
      rd(A_CNT, v); check($sformatf("R4 vec%0d count", k), v, packSecs(left));
      rd(A_ST, v);  check($sformatf("R5 vec%0d pending", k), v, {31'd0, left == 0});
    end

    // R3 disabled counter holds
    wr(A_RUN, 0); wr(A_CNT, packSecs(100)); tick(4);
    rd(A_CNT, v); check("R3 disabled hold", v, packSecs(100));

    // R9 zero write clears without pending
    wr(A_ST, 1); wr(A_RUN, 32'h100); wr(A_CNT, 0); tick(3);
    rd(A_CNT, v); check("R9 zero load", v, 0);
    rd(A_ST, v);  check("R9 no pending", v, 0);

    // R9 load beats tick
    @(negedge clk); wrEn = 1; wrAddr = A_CNT; wrData = packSecs(10); secTick = 1;
    @(negedge clk); wrEn = 0; secTick = 0;
    rd(A_CNT, v); check("R9 load wins", v, packSecs(10));

    // R6 irq gating
    wr(A_CNT, packSecs(1)); tick(1);
    rd(A_ST, v); check("R5 pend set", v, 1);
    check("R6 irq masked", {31'd0, irqOut}, 0);
    wr(A_IRQ, 1);
    check("R6 irq on", {31'd0, irqOut}, 1);
    // R7 write 0 keeps, write 1 clears
    wr(A_ST, 0);
    rd(A_ST, v); check("R7 zero write keeps", v, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R7 w1c", v, 0);
    check("R6 irq off", {31'd0, irqOut}, 0);

    // R8 set wins over clear
    wr(A_CNT, packSecs(1));
    @(negedge clk); wrEn = 1; wrAddr = A_ST; wrData = 1; secTick = 1;
    @(negedge clk); wrEn = 0; secTick = 0;
    rd(A_ST, v); check("R8 set wins", v, 1);
    check("R8 irq", {31'd0, irqOut}, 1);
    finish();
  end
endmodule